// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It does this by reading through a two-level translation tree held in memory. A root input names the physical page that holds the current process's directory. On each accepted request the walker reads one directory word, then, if that word is marked present, one table word. It then returns a physical address or a page fault.

The fault says which of the two levels ended the walk. Reads go out over a plain request/response port, and the memory may take any number of cycles to answer. A missing directory word ends the walk at once, and no table read is made. The walker handles one translation at a time. A client raises a request whenever the walker is idle and waits for the one-cycle completion pulse.

Top module: `pt_walker`

## Requirements
- R1: During reset and after it is released, `busy_o`, `done_o` and `mem_req_o` are all 0.
- R2: A request is taken only in a cycle where `busy_o` is 0. `busy_o` goes to 1 in the next cycle and stays at 1 up to and including the cycle of the done pulse. A `req_valid_i` held high through the done cycle is not taken in that cycle; it is taken in the following idle cycle. `req_addr_i` and `root_i` are sampled only in the cycle the request is taken, and later changes have no effect on that walk.
- R3: The first read address is `{root[31:12], 12'h000} + 4 * lin[31:22]`. The low 12 bits of the root value are ignored.
- R4: In every entry, bit 0 is the present bit and bits 31:12 hold the next-level page base. After a present directory word `de`, the second read address is `{de[31:12], 12'h000} + 4 * lin[21:12]`.
- R5: If the directory word has bit 0 clear, the walk completes with `fault_o`=1 and `fault_level_o`=0 (directory level), and no second read is issued.
- R6: If the table word has bit 0 clear, the walk completes with `fault_o`=1 and `fault_level_o`=1 (table level).
- R7: If both words are present, the walk completes with `fault_o`=0 and `paddr_o = {te[31:12], lin[11:0]}`.
- R8: A read keeps `mem_req_o` high with a stable `mem_addr_o` until a cycle where `mem_rvalid_i` is 1, and that cycle may be the first cycle of the read. A `mem_rvalid_i` seen while `mem_req_o` is 0 is ignored.
- R9: `done_o` is a one-cycle pulse in the cycle after the final read response, with the result on `paddr_o`, `fault_o` and `fault_level_o`. `busy_o` is 0 in the cycle after it. With zero-wait memory, a full walk gives `done_o` three cycles after the accept edge, and a directory-fault walk gives it two cycles after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_i | input | 32 | Physical address of the current directory page |
| req_valid_i | input | 1 | Translation request |
| req_addr_i | input | 32 | Linear address to translate |
| busy_o | output | 1 | Walk in progress (through the done cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| paddr_o | output | 32 | Physical address (valid with done, no fault) |
| fault_o | output | 1 | Page fault (valid with done) |
| fault_level_o | output | 1 | Failing level: 0 directory, 1 table |
| mem_req_o | output | 1 | Read request, held until response |
| mem_addr_o | output | 32 | Read word address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |

## Verification
The completion pulse and the arrival of the next request can fall in the same cycle. The bench provokes this by holding `req_valid_i` high straight through a walk. It then expects `busy_o` to be low in the cycle after the pulse and high again in the cycle after that. A walker that took the request during the pulse would show `busy_o` still high.

The memory model also returns responses in the very first cycle of a read, back to back with the next read. This checks that the response which ends the directory read and the start of the table read happen on consecutive edges, with the cycle count judged against the zero-wait latency.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_DONE = 2'd3
  } walk_st_t;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } walk_lvl_t;

  localparam int ENTRY_SHIFT = 2;
endpackage

// File: rtl/pw_rst_sync.sv
module pw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr import pw_pkg::*; #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [AW-OFF_W-1:0] frame_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [AW-1:0]       addr_o
);
  logic [AW-1:0] page_base;
  logic [AW-1:0] byte_off;

  assign page_base = {frame_i, {OFF_W{1'b0}}};
  assign byte_off  = AW'(idx_i) << ENTRY_SHIFT;
  assign addr_o    = page_base + byte_off;
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl import pw_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic mem_rvalid_i,
  input  logic entry_ok_i,
  output logic accept_o,
  output logic dir_take_o,
  output logic tbl_take_o,
  output logic sel_tbl_o,
  output logic busy_o,
  output logic done_o,
  output logic mem_req_o
);
  walk_st_t st_q, st_n;

  always_comb begin
    st_n     = st_q;
    accept_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          st_n     = ST_DIR;
        end
      end
      ST_DIR: begin
        if (mem_rvalid_i) st_n = entry_ok_i ? ST_TBL : ST_DONE;
      end
      ST_TBL: begin
        if (mem_rvalid_i) st_n = ST_DONE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign dir_take_o = (st_q == ST_DIR) && mem_rvalid_i;
  assign tbl_take_o = (st_q == ST_TBL) && mem_rvalid_i;
  assign sel_tbl_o  = (st_q == ST_TBL);
  assign mem_req_o  = (st_q == ST_DIR) || (st_q == ST_TBL);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
endmodule

// File: rtl/pw_datapath.sv
module pw_datapath import pw_pkg::*; #(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept_i,
  input  logic                         dir_take_i,
  input  logic                         tbl_take_i,
  input  logic                         sel_tbl_i,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] req_addr_i,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] root_i,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] rdata_i,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_addr_o,
  output logic                         entry_ok_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] paddr_o,
  output logic                         fault_o,
  output logic                         fault_lvl_o
);
  localparam int AW      = DIR_W + TBL_W + OFF_W;
  localparam int BASE_W  = AW - OFF_W;
  localparam int IDX_MAX = (DIR_W > TBL_W) ? DIR_W : TBL_W;

  logic [AW-1:0]     lin_q, lin_n;
  logic [BASE_W-1:0] root_q, root_n;
  logic [BASE_W-1:0] tbase_q, tbase_n;
  logic [AW-1:0]     paddr_q, paddr_n;
  logic              fault_q, fault_n;
  walk_lvl_t         lvl_q, lvl_n;
  logic              res_ld;

  logic [BASE_W-1:0]  lvl_base [2];
  logic [IDX_MAX-1:0] lvl_idx  [2];
  logic [AW-1:0]      lvl_addr [2];

  logic unused_low_bits;
  assign unused_low_bits = ^{root_i[OFF_W-1:0], rdata_i[OFF_W-1:1]};

  assign entry_ok_o = rdata_i[0];

  assign lvl_base[0] = root_q;
  assign lvl_base[1] = tbase_q;
  assign lvl_idx[0]  = IDX_MAX'(lin_q[AW-1 -: DIR_W]);
  assign lvl_idx[1]  = IDX_MAX'(lin_q[OFF_W +: TBL_W]);

  for (genvar g = 0; g < 2; g++) begin : g_level
    pw_entry_addr #(
      .AW   (AW),
      .OFF_W(OFF_W),
      .IDX_W(IDX_MAX)
    ) u_ea (
      .frame_i(lvl_base[g]),
      .idx_i  (lvl_idx[g]),
      .addr_o (lvl_addr[g])
    );
  end

  assign mem_addr_o = sel_tbl_i ? lvl_addr[1] : lvl_addr[0];

  always_comb begin
    lin_n   = lin_q;
    root_n  = root_q;
    tbase_n = tbase_q;
    if (accept_i) begin
      lin_n  = req_addr_i;
      root_n = root_i[AW-1:OFF_W];
    end
    if (dir_take_i && entry_ok_o) tbase_n = rdata_i[AW-1:OFF_W];
  end

  assign res_ld = (dir_take_i && !entry_ok_o) || tbl_take_i;

  always_comb begin
    paddr_n = paddr_q;
    fault_n = fault_q;
    lvl_n   = lvl_q;
    if (res_ld) begin
      fault_n = !entry_ok_o;
      lvl_n   = tbl_take_i ? LVL_TBL : LVL_DIR;
      paddr_n = (tbl_take_i && entry_ok_o) ?
                {rdata_i[AW-1:OFF_W], lin_q[OFF_W-1:0]} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q   <= '0;
      root_q  <= '0;
      tbase_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= LVL_DIR;
    end else begin
      lin_q   <= lin_n;
      root_q  <= root_n;
      tbase_q <= tbase_n;
      paddr_q <= paddr_n;
      fault_q <= fault_n;
      lvl_q   <= lvl_n;
    end
  end

  assign paddr_o     = paddr_q;
  assign fault_o     = fault_q;
  assign fault_lvl_o = lvl_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] root_i,
  input  logic                         req_valid_i,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] req_addr_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] paddr_o,
  output logic                         fault_o,
  output logic                         fault_level_o,
  output logic                         mem_req_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_addr_o,
  input  logic                         mem_rvalid_i,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] mem_rdata_i
);
  logic rst_sync_n;
  logic accept, dir_take, tbl_take, sel_tbl, entry_ok;

  pw_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  pw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid_i (req_valid_i),
    .mem_rvalid_i(mem_rvalid_i),
    .entry_ok_i  (entry_ok),
    .accept_o    (accept),
    .dir_take_o  (dir_take),
    .tbl_take_o  (tbl_take),
    .sel_tbl_o   (sel_tbl),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o)
  );

  pw_datapath #(
    .DIR_W(DIR_W),
    .TBL_W(TBL_W),
    .OFF_W(OFF_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept_i   (accept),
    .dir_take_i (dir_take),
    .tbl_take_i (tbl_take),
    .sel_tbl_i  (sel_tbl),
    .req_addr_i (req_addr_i),
    .root_i     (root_i),
    .rdata_i    (mem_rdata_i),
    .mem_addr_o (mem_addr_o),
    .entry_ok_o (entry_ok),
    .paddr_o    (paddr_o),
    .fault_o    (fault_o),
    .fault_lvl_o(fault_level_o)
  );
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          fault_level_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i
);
  logic [1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rd_cnt <= 2'd0;
    else if (!busy_o)                   rd_cnt <= 2'd0;
    else if (mem_req_o && mem_rvalid_i) rd_cnt <= rd_cnt + 2'd1;
  end

  assert_idle_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  assert_start_on_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_valid_i));

  assert_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  assert_read_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_dir_fault_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o && !fault_level_o) |-> (rd_cnt == 2'd1));

  assert_table_two_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (!fault_o || fault_level_o)) |-> (rd_cnt == 2'd2));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_done_after_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_req_o && mem_rvalid_i));
endmodule

bind pt_walker pw_checker #(.AW(DIR_W + TBL_W + OFF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_level_o(fault_level_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        busy_o, done_o, fault_o, fault_level_o, mem_req_o;
  logic [31:0] paddr_o, mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int total = 0;
  int bad = 0;

  int vmode = 0;
  int lmode = 0;
  int rd_n = 0;
  int cnt = 0;
  bit fresh = 1'b1;
  bit stab_bad = 1'b0;
  logic [31:0] held;
  logic [31:0] rd_seen [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .root_i       (root_i),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .paddr_o      (paddr_o),
    .fault_o      (fault_o),
    .fault_level_o(fault_level_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a, input int vm, input int rn);
    logic [31:0] h;
    h = (a ^ 32'h5A17C3E9) * 32'h9E3779B1;
    h = h ^ (h >> 15);
    case (vm)
      1:       h[0] = 1'b1;
      2:       h[0] = (rn == 0) ? 1'b0 : 1'b1;
      3:       h[0] = (rn == 0) ? 1'b1 : 1'b0;
      default: h[0] = h[3] | h[4];
    endcase
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // memory model: variable latency, stray responses while idle
  always @(negedge clk) begin
    if (!mem_req_o) begin
      fresh = 1'b1;
      if (lmode == 0 && ($urandom % 3) == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = $urandom;
      end else begin
        mem_rvalid_i = 1'b0;
      end
    end else begin
      if (fresh || mem_rvalid_i) begin
        fresh = 1'b0;
        cnt = (lmode == 1) ? 0 : (lmode == 2) ? 5 : int'($urandom % 4);
        if (rd_n < 3) rd_seen[rd_n] = mem_addr_o;
        rd_n++;
        held = mem_addr_o;
      end else if (mem_addr_o != held) begin
        stab_bad = 1'b1;
      end
      if (cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_word(mem_addr_o, vmode, rd_n - 1);
      end else begin
        cnt--;
        mem_rvalid_i = 1'b0;
      end
    end
  end

  task automatic walk(input logic [31:0] la, input logic [31:0] bs,
                      input int vm, input int lm, input bit hold);
    logic [31:0] da, ta, de, te, ep;
    bit ef, el;
    int nrd, cyc;
    da = {bs[31:12], 12'h000} + {20'h0, la[31:22], 2'b00};
    de = mem_word(da, vm, 0);
    ta = '0; ep = '0; el = 1'b0;
    if (!de[0]) begin
      ef = 1'b1; el = 1'b0; nrd = 1;
    end else begin
      ta = {de[31:12], 12'h000} + {20'h0, la[21:12], 2'b00};
      te = mem_word(ta, vm, 1);
      nrd = 2;
      if (!te[0]) begin ef = 1'b1; el = 1'b1; end
      else begin ef = 1'b0; ep = {te[31:12], la[11:0]}; end
    end

    @(negedge clk);
    vmode = vm; lmode = lm; rd_n = 0; stab_bad = 1'b0;
    req_valid_i = 1'b1; req_addr_i = la; root_i = bs;
    @(negedge clk);
    chk(busy_o == 1'b1, "R2 busy after accept", 32'(busy_o), 32'd1);
    if (!hold) req_valid_i = 1'b0;
    if (!hold) begin req_addr_i = ~la; root_i = ~bs; end
    cyc = 1;
    while (!done_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o == 1'b1, "R9 done seen", 32'(done_o), 32'd1);
    chk(busy_o == 1'b1, "R2 busy in done cycle", 32'(busy_o), 32'd1);
    chk(rd_n == nrd, "R5 read count", 32'(rd_n), 32'(nrd));
    chk(rd_seen[0] == da, "R3 directory address", rd_seen[0], da);
    if (nrd == 2) chk(rd_seen[1] == ta, "R4 table address", rd_seen[1], ta);
    chk(fault_o == ef, "R5 R6 fault flag", 32'(fault_o), 32'(ef));
    if (ef) chk(fault_level_o == el, "R6 fault level", 32'(fault_level_o), 32'(el));
    else    chk(paddr_o == ep, "R7 physical address", paddr_o, ep);
    chk(!stab_bad, "R8 address held while waiting", 32'(stab_bad), 32'd0);
    if (lm == 1) chk(cyc == nrd + 1, "R9 zero-wait latency", 32'(cyc), 32'(nrd + 1));
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0, "R2 R9 idle after done", 32'(busy_o), 32'd0);
    if (hold) begin
      @(negedge clk);
      chk(busy_o == 1'b1, "R2 held request taken after done", 32'(busy_o), 32'd1);
      req_valid_i = 1'b0;
      cyc = 0;
      while (busy_o && cyc < 100) begin @(negedge clk); cyc++; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R1 outputs in reset",
        {29'h0, busy_o, done_o, mem_req_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R1 outputs after reset",
        {29'h0, busy_o, done_o, mem_req_o}, 32'd0);

    walk(32'h0040_3ABC, 32'h0010_0000, 1, 1, 1'b0);
    walk(32'h1234_5678, 32'h0020_0000, 2, 1, 1'b0);
    walk(32'h89AB_CDEF, 32'h0030_0000, 3, 2, 1'b0);
    walk(32'h0000_0000, 32'h1234_5FFF, 1, 0, 1'b0);
    walk(32'hFFFF_FFFF, 32'hFFFF_F000, 1, 2, 1'b0);
    walk(32'hFFC0_0FFF, 32'h0000_0000, 3, 1, 1'b0);
    walk(32'h0555_5555, 32'h0040_0123, 1, 1, 1'b1);

    for (int i = 0; i < 60; i++) begin
      walk($urandom, $urandom, 0, 0, 1'b0);
    end

    summary();
    $finish;
  end
endmodule